// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a register-mapped watchdog. A 16-bit up-counter advances once per prescaled tick of one chosen count source. When the count reaches a programmed compare value, the block raises a reset request for exactly one system clock cycle. The counter then stays at that value. Software keeps the system alive by writing zero to the counter register before the compare value is reached.

Three count sources reach the block as single-cycle enables that are synchronous to the system clock:

- the peripheral clock,
- the real-time clock,
- an external clock.

A control register picks one of these sources with a one-hot field. The same register sets a power-of-four prescale ratio from 1 to 1024. The prescaler counts pulses of the chosen source and issues one tick for every N pulses.

To configure the block, software follows this order:

1. Disable the counter.
2. Write the prescale code with no source selected.
3. Load the compare value.
4. Clear the counter.
5. Write the control register again, this time with the source bit set.
6. Enable the counter.

Top module: `wdog_prescaled`

## Requirements
- R1: After a synchronous reset, every register reads 0 and `rst_req_o` is low.
- R2: Register map (byte address, word aligned, address bits above 3 must be zero):
  - 0x0 holds the 16-bit compare value.
  - 0x4 holds the enable in bit 0.
  - 0x8 holds the live counter.
  - 0xC holds the control word: source select in [2:0] and prescale code in [5:3].
  - `bus_rdata_o` shows the addressed register one cycle after the address is presented.
  - Unused bits and unmapped addresses read as 0.
- R3: While enabled, the counter rises by exactly one for each prescaled tick and never by more.
- R4: Source select bit 0 chooses `src_pclk_i`, bit 1 chooses `src_rtc_i` and bit 2 chooses `src_ext_i`. Pulses on sources that are not selected leave the counter unchanged.
- R5: When the counter equals the compare value while enabled, `rst_req_o` goes high in the next cycle for exactly one cycle. A match that persists raises it only once. Disabling and then re-enabling re-arms it.
- R6: Once the counter equals the compare value, further ticks leave it unchanged.
- R7: A write to the counter register loads the written value, so writing 0 is the keep-alive ping.
- R8: While the enable bit is 0, source pulses leave the counter unchanged.
- R9: Prescale codes 0 to 5 divide the selected source by 4 to the power of the code: 1, 4, 16, 64, 256 and 1024.
- R10: Prescale codes 6 and 7 divide by 1024.
- R11: A source select field with no bit set, or with more than one bit set, produces no ticks.
- R12: The prescaler phase restarts at zero on a control write, on a counter write, and while the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pclk_i | input | 1 | Peripheral clock enable pulse |
| src_rtc_i | input | 1 | Real-time clock enable pulse |
| src_ext_i | input | 1 | External clock enable pulse |
| bus_addr_i | input | ADDR_W (8) | Register byte address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | CNT_W (16) | Write data |
| bus_rdata_o | output | CNT_W (16) | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The assertions check several properties on every cycle:

- The reset request is one cycle wide, and it follows a match that was seen while the block was enabled.
- The counter stays put at a match and while the block is disabled.
- Without a counter write, the counter moves by at most one per cycle.
- A select field that is not one-hot freezes the counter.

Only the bench scenarios can show the rest:

- the exact division ratio of each prescale code, including the reserved codes;
- which source drives the count;
- that a write restarts the prescaler phase;
- that a disable followed by an enable re-arms the request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // word index of each register (byte address bits [3:2])
  typedef enum logic [1:0] {
    REG_CMP  = 2'd0,
    REG_EN   = 2'd1,
    REG_CNT  = 2'd2,
    REG_CTRL = 2'd3
  } wdog_reg_e;

  localparam int SRC_N = 3;   // pclk, rtc, ext

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              en_o,
  output logic [SRC_N-1:0]  sel_o,
  output logic [CODE_W-1:0] code_o,
  output logic              cnt_wr_o,
  output logic              ctrl_wr_o,
  output logic [CNT_W-1:0]  rdata_o
);

  localparam int CTRL_W = SRC_N + CODE_W;

  logic [CNT_W-1:0]  cmp_q;
  logic              en_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              hit;
  wdog_reg_e         idx;

  assign hit = (addr_i[1:0] == 2'b00) && (addr_i[ADDR_W-1:4] == '0);
  assign idx = wdog_reg_e'(addr_i[3:2]);

  assign cnt_wr_o  = we_i && hit && (idx == REG_CNT);
  assign ctrl_wr_o = we_i && hit && (idx == REG_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      ctrl_q <= '0;
    end else if (we_i && hit) begin
      case (idx)
        REG_CMP:  cmp_q  <= wdata_i;
        REG_EN:   en_q   <= wdata_i[0];
        REG_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (!hit) begin
      rdata_o <= '0;
    end else begin
      case (idx)
        REG_CMP:  rdata_o <= cmp_q;
        REG_EN:   rdata_o <= {{(CNT_W-1){1'b0}}, en_q};
        REG_CNT:  rdata_o <= count_i;
        default:  rdata_o <= {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      endcase
    end
  end

  assign cmp_o  = cmp_q;
  assign en_o   = en_q;
  assign sel_o  = ctrl_q[SRC_N-1:0];
  assign code_o = ctrl_q[CTRL_W-1:SRC_N];

endmodule

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
  import wdog_pkg::*;
#(
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  src_i,
  input  logic [SRC_N-1:0]  sel_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              restart_i,
  output logic              tick_o
);

  localparam int PRE_W = 2 * MAX_CODE;

  logic [SRC_N-1:0]  gated;
  logic              src_hit;
  logic [CODE_W-1:0] eff_code;
  logic [PRE_W-1:0]  limit;
  logic [PRE_W-1:0]  phase_q;

  for (genvar g = 0; g < SRC_N; g++) begin : g_gate
    assign gated[g] = sel_i[g] & src_i[g];
  end

  assign src_hit  = ($countones(sel_i) == 1) && (|gated);
  assign eff_code = (code_i > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code_i;
  assign limit    = PRE_W'((32'd1 << (2 * eff_code)) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      phase_q <= '0;
    end else if (src_hit) begin
      phase_q <= (phase_q == limit) ? '0 : phase_q + 1'b1;
    end
  end

  assign tick_o = src_hit && (phase_q == limit) && !restart_i;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] count_o,
  output logic             req_o
);

  logic [CNT_W-1:0] count_q;
  logic             fired_q;
  logic             match;

  assign match = (count_q == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      fired_q <= 1'b0;
      req_o   <= 1'b0;
    end else if (load_i) begin
      count_q <= load_val_i;
      fired_q <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      if (en_i && tick_i && !match) begin
        count_q <= count_q + 1'b1;
      end
      req_o   <= en_i && match && !fired_q;
      fired_q <= en_i && match;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int CODE_W   = 3,
  parameter int MAX_CODE = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_pclk_i,
  input  logic              src_rtc_i,
  input  logic              src_ext_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              rst_req_o
);

  logic [CNT_W-1:0]  cmp_w;
  logic [CNT_W-1:0]  count_w;
  logic              en_w;
  logic [SRC_N-1:0]  sel_w;
  logic [CODE_W-1:0] code_w;
  logic              cnt_wr_w;
  logic              ctrl_wr_w;
  logic              tick_w;

  wdog_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (bus_addr_i),
    .we_i      (bus_we_i),
    .wdata_i   (bus_wdata_i),
    .count_i   (count_w),
    .cmp_o     (cmp_w),
    .en_o      (en_w),
    .sel_o     (sel_w),
    .code_o    (code_w),
    .cnt_wr_o  (cnt_wr_w),
    .ctrl_wr_o (ctrl_wr_w),
    .rdata_o   (bus_rdata_o)
  );

  wdog_tick_gen #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .src_i     ({src_ext_i, src_rtc_i, src_pclk_i}),
    .sel_i     (sel_w),
    .code_i    (code_w),
    .restart_i (cnt_wr_w || ctrl_wr_w || !en_w),
    .tick_o    (tick_w)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_w),
    .tick_i     (tick_w),
    .load_i     (cnt_wr_w),
    .load_val_i (bus_wdata_i),
    .cmp_i      (cmp_w),
    .count_o    (count_w),
    .req_o      (rst_req_o)
  );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int CNT_W = 16,
  parameter int SRC_N = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             cnt_wr,
  input logic [SRC_N-1:0] sel,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp,
  input logic             rst_req
);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R5

  AST_REQ_AFTER_MATCH: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(en && (count == cmp) && !cnt_wr)); // R5

  AST_HOLD_AT_MATCH: assert property (@(posedge clk) disable iff (rst)
    (en && (count == cmp) && !cnt_wr) |=> $stable(count)); // R6

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr) |=> $stable(count)); // R8

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> ((count == $past(count)) || (count == $past(count) + 1'b1))); // R3

  AST_BAD_SELECT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (($countones(sel) != 1) && !cnt_wr) |=> $stable(count)); // R11

endmodule

bind wdog_prescaled wdog_checker #(.CNT_W(CNT_W), .SRC_N(wdog_pkg::SRC_N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en_w),
  .cnt_wr  (cnt_wr_w),
  .sel     (sel_w),
  .count   (count_w),
  .cmp     (cmp_w),
  .rst_req (rst_req_o)
);

// File: tb/test_wdog_prescaled.sv
`timescale 1ns/1ps
module test_wdog_prescaled;

  localparam logic [7:0] A_CMP  = 8'h00;
  localparam logic [7:0] A_EN   = 8'h04;
  localparam logic [7:0] A_CNT  = 8'h08;
  localparam logic [7:0] A_CTRL = 8'h0C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  src = 3'b000;   // {ext, rtc, pclk}
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req;

  logic        rd_strobe = 1'b0;
  logic        rd_due = 1'b0;
  int          n_tests = 0;
  int          n_fail = 0;
  int          pulses = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;   // 50 MHz

  wdog_prescaled i_wdog_prescaled (
    .clk         (clk),
    .rst         (rst),
    .src_pclk_i  (src[0]),
    .src_rtc_i   (src[1]),
    .src_ext_i   (src[2]),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .rst_req_o   (rst_req)
  );

  // monitor: read data is registered, so compare one edge after the strobe
  always @(posedge clk) rd_due <= rd_strobe;

  always @(negedge clk) begin
    if (!rst && rst_req) pulses <= pulses + 1;
    if (rd_due && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s actual=0x%04h expected=0x%04h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: push the expected value, then issue the read
  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      src[which] = 1'b1;
      @(negedge clk);
      src[which] = 1'b0;
    end
    @(negedge clk);
  endtask

  task automatic chk_pulses(input int e, input string t);
    repeat (2) @(negedge clk);
    n_tests++;
    if (pulses != e) begin
      n_fail++;
      $display("FAIL %s pulses actual=%0d expected=%0d", t, pulses, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(A_CMP, 16'h0000, "R1 cmp");
    rd(A_EN, 16'h0000, "R1 en");
    rd(A_CNT, 16'h0000, "R1 cnt");
    rd(A_CTRL, 16'h0000, "R1 ctrl");
    chk_pulses(0, "R1 req");
    // R2 register map and masking
    wr(A_CMP, 16'hBEEF);   rd(A_CMP, 16'hBEEF, "R2 cmp");
    wr(A_CTRL, 16'hFFFF);  rd(A_CTRL, 16'h003F, "R2 ctrl mask");
    wr(A_EN, 16'h00FF);    rd(A_EN, 16'h0001, "R2 en mask");
    rd(8'h10, 16'h0000, "R2 unmapped");
    // configuration order, divide by 1 on pclk
    wr(A_EN, 0); wr(A_CTRL, 16'h0000); wr(A_CMP, 16'd5); wr(A_CNT, 0);
    wr(A_CTRL, 16'h0001); wr(A_EN, 1);
    pulse(0, 3);  rd(A_CNT, 16'd3, "R3 count by one");
    pulse(1, 4); pulse(2, 2); rd(A_CNT, 16'd3, "R4 unselected sources");
    pulse(0, 2);  rd(A_CNT, 16'd5, "R5 reach compare");
    chk_pulses(1, "R5 single request");
    pulse(0, 3);  rd(A_CNT, 16'd5, "R6 hold at match");
    chk_pulses(1, "R6 no repeat request");
    wr(A_CNT, 0); rd(A_CNT, 16'd0, "R7 ping clears");
    pulse(0, 1);  rd(A_CNT, 16'd1, "R7 count after ping");
    wr(A_CNT, 3); rd(A_CNT, 16'd3, "R7 load value");
    wr(A_EN, 0);  pulse(0, 4); rd(A_CNT, 16'd3, "R8 disabled frozen");
    // divide by 4
    wr(A_CMP, 16'hFFFF); wr(A_CTRL, 16'h0009); wr(A_CNT, 0); wr(A_EN, 1);
    pulse(0, 8);  rd(A_CNT, 16'd2, "R9 div4 eight pulses");
    pulse(0, 3);  rd(A_CNT, 16'd2, "R9 div4 partial");
    pulse(0, 1);  rd(A_CNT, 16'd3, "R9 div4 completes");
    // R12 phase restart on counter write
    pulse(0, 2); wr(A_CNT, 0);
    pulse(0, 2);  rd(A_CNT, 16'd0, "R12 phase restarted");
    pulse(0, 2);  rd(A_CNT, 16'd1, "R12 tick after four");
    // divide by 16
    wr(A_CTRL, 16'h0011); wr(A_CNT, 0);
    pulse(0, 32); rd(A_CNT, 16'd2, "R9 div16");
    pulse(0, 15); rd(A_CNT, 16'd2, "R9 div16 partial");
    // divide by 1024 on rtc, code 5
    wr(A_CTRL, 16'h002A); wr(A_CNT, 0);
    pulse(1, 1023); rd(A_CNT, 16'd0, "R9 div1024 partial");
    pulse(1, 1);    rd(A_CNT, 16'd1, "R9 div1024");
    // reserved codes on ext and pclk
    wr(A_CTRL, 16'h003C); wr(A_CNT, 0);
    pulse(2, 1023); rd(A_CNT, 16'd0, "R10 code7 partial");
    pulse(2, 1);    rd(A_CNT, 16'd1, "R10 code7");
    wr(A_CTRL, 16'h0031); wr(A_CNT, 0);
    pulse(0, 1024); rd(A_CNT, 16'd1, "R10 code6");
    // R11 bad select fields
    wr(A_CTRL, 16'h0000); wr(A_CNT, 0);
    pulse(0, 3); pulse(1, 3); rd(A_CNT, 16'd0, "R11 no select");
    wr(A_CTRL, 16'h0003);
    pulse(0, 3); pulse(1, 3); rd(A_CNT, 16'd0, "R11 two selects");
    wr(A_CTRL, 16'h0004);
    pulse(2, 2); rd(A_CNT, 16'd2, "R4 ext source");
    // R5 immediate match, then re-arm through disable
    wr(A_CMP, 16'd2);
    chk_pulses(2, "R5 match on compare write");
    wr(A_EN, 0); wr(A_EN, 1);
    chk_pulses(3, "R5 re-armed after disable");
    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule